// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This block sits beside a calendar clock's counters and raises an alarm when the running time reaches a programmed point. It holds three alarm registers, for minutes, hours and day of the week, plus a control register. The top bit of each alarm register is a mask. The pattern of the three masks sets how often the alarm repeats: every minute, hourly on a minute match, daily on an hour-and-minute match, or weekly on a full match.

The compare runs only on a 100 Hz tick where the hundredths counter has just wrapped to 00, and only when the seconds counter reads 00. Seconds therefore have just rolled from 59 to 00. The counter values are the post-update ones, supplied by the clock block.

A hit sets a read-only flag. Any access to an alarm register, read or write, clears it. Control bits do three things: mask the interrupt, pick level or fixed-length pulse signalling, and hand the interrupt output to an external watchdog alarm instead.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, the alarm registers (03h, 05h, 07h) and the control register (0Bh) read 00h, the flag is 0 and `alarm_irq` is low.
- R2: With all three mask bits set (bit 7 of 03h, 05h and 07h), an alarm occurs on every compare point where seconds read 00h. A compare point with any other seconds value gives no alarm.
- R3: Masks minutes=0, hours=1, days=1: an alarm needs `cur_min` equal to bits 6:0 of 03h.
- R4: Masks minutes=0, hours=0, days=1: an alarm needs both the minutes and the hours (`cur_hour` against bits 6:0 of 05h) to match.
- R5: Masks all 0: an alarm needs the minutes, the hours and the day (`cur_day` against bits 2:0 of 07h) to match.
- R6: Any other mask pattern never produces an alarm, even when every field matches.
- R7: A compare point requires both `tick_100hz` and `hund_wrap` in the same cycle. Either one alone does nothing.
- R8: Register 07h reads its bits 6:3 as 0 whatever was written to them.
- R9: The flag is bit 0 of 0Bh. It reads 1 from the cycle after an alarm. Writes to 0Bh cannot change it. A read or write of 03h, 05h or 07h with `bus_en` high clears it.
- R10: Control bit 2 set to 1 holds the time-of-day interrupt low, while the flag still sets.
- R11: Control bit 4 set to 1 selects pulse mode. The interrupt and the flag are then both 1 for exactly PULSE_CLKS cycles after an alarm, then both return to 0.
- R12: Control bit 4 at 0 selects level mode. The interrupt stays high until the flag is cleared.
- R13: Control bit 6 set to 1 drives `alarm_irq` from `wdog_alarm`. At 0, `alarm_irq` carries the time-of-day interrupt. Switching the route does not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle strobe at the hundredths rate |
| hund_wrap | input | 1 | Hundredths counter has just wrapped to 00 |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours field, including format bits |
| cur_day | input | 3 | Current day of week |
| wdog_alarm | input | 1 | Watchdog interrupt request |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| alarm_irq | output | 1 | Interrupt output, active high |

## Verification
Register writes, the flag and the pulse counter update on the rising edge that ends the stimulus cycle, so they are due one edge later. `bus_rdata` and the routed `alarm_irq` are combinational, so they are valid in the same cycle. The driver applies one stimulus cycle at a falling edge and queues the expected interrupt and readback for that cycle. The monitor compares them two nanoseconds after the next rising edge, before any input moves. Register state is observed through `bus_rdata` with `bus_en` low, which leaves the flag undisturbed.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  localparam int unsigned REG_AW = 4;
  localparam int unsigned REG_DW = 8;

  // register offsets; the clock block and software rely on these
  localparam logic [REG_AW-1:0] ADR_MIN_ALM = 4'h3;
  localparam logic [REG_AW-1:0] ADR_HR_ALM  = 4'h5;
  localparam logic [REG_AW-1:0] ADR_DAY_ALM = 4'h7;
  localparam logic [REG_AW-1:0] ADR_CTRL    = 4'hB;

  // control register bit positions
  localparam int unsigned CB_ROUTE = 6;
  localparam int unsigned CB_PULSE = 4;
  localparam int unsigned CB_TMASK = 2;
  localparam int unsigned CB_LOW   = 2;  // lowest stored control bit

  typedef enum logic [2:0] {
    RATE_EVERY_MIN,
    RATE_MIN_EQ,
    RATE_HR_MIN_EQ,
    RATE_DAY_HR_MIN_EQ,
    RATE_BAD
  } rate_e;

  function automatic rate_e decode_rate(input logic m_min, input logic m_hr,
                                        input logic m_day);
    rate_e r;
    unique case ({m_min, m_hr, m_day})
      3'b111:  r = RATE_EVERY_MIN;
      3'b011:  r = RATE_MIN_EQ;
      3'b001:  r = RATE_HR_MIN_EQ;
      3'b000:  r = RATE_DAY_HR_MIN_EQ;
      default: r = RATE_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  input  logic              flag,
  output logic [6:0]        min_alm,
  output logic              min_msk,
  output logic [6:0]        hr_alm,
  output logic              hr_msk,
  output logic [2:0]        day_alm,
  output logic              day_msk,
  output logic              route_wdog,
  output logic              pulse_mode,
  output logic              tod_mask,
  output logic              alm_access,
  output logic [REG_DW-1:0] bus_rdata
);

  localparam int unsigned CTRL_W = REG_DW - CB_LOW;

  logic [REG_DW-1:0] min_q, min_d;
  logic [REG_DW-1:0] hr_q,  hr_d;
  logic [3:0]        day_q, day_d;
  logic [CTRL_W-1:0] ctl_q, ctl_d;
  logic              wr_en;

  assign wr_en = bus_en & bus_we;

  // next state
  always_comb begin
    min_d = min_q;
    hr_d  = hr_q;
    day_d = day_q;
    ctl_d = ctl_q;
    if (wr_en) begin
      unique case (bus_addr)
        ADR_MIN_ALM: min_d = bus_wdata;
        ADR_HR_ALM:  hr_d  = bus_wdata;
        ADR_DAY_ALM: day_d = {bus_wdata[REG_DW-1], bus_wdata[2:0]};
        ADR_CTRL:    ctl_d = bus_wdata[REG_DW-1:CB_LOW];
        default: ;
      endcase
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      min_q <= min_d;
      hr_q  <= hr_d;
      day_q <= day_d;
      ctl_q <= ctl_d;
    end
  end

  assign min_alm    = min_q[6:0];
  assign min_msk    = min_q[REG_DW-1];
  assign hr_alm     = hr_q[6:0];
  assign hr_msk     = hr_q[REG_DW-1];
  assign day_alm    = day_q[2:0];
  assign day_msk    = day_q[3];
  assign route_wdog = ctl_q[CB_ROUTE - CB_LOW];
  assign pulse_mode = ctl_q[CB_PULSE - CB_LOW];
  assign tod_mask   = ctl_q[CB_TMASK - CB_LOW];

  assign alm_access = bus_en & ((bus_addr == ADR_MIN_ALM) |
                                (bus_addr == ADR_HR_ALM)  |
                                (bus_addr == ADR_DAY_ALM));

  // readback, independent of bus_en
  always_comb begin
    unique case (bus_addr)
      ADR_MIN_ALM: bus_rdata = min_q;
      ADR_HR_ALM:  bus_rdata = hr_q;
      ADR_DAY_ALM: bus_rdata = {day_q[3], 4'b0000, day_q[2:0]};
      ADR_CTRL:    bus_rdata = {ctl_q, 1'b0, flag};
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic       tick_100hz,
  input  logic       hund_wrap,
  input  logic [6:0] cur_sec,
  input  logic [6:0] cur_min,
  input  logic [6:0] cur_hour,
  input  logic [2:0] cur_day,
  input  logic [6:0] min_alm,
  input  logic       min_msk,
  input  logic [6:0] hr_alm,
  input  logic       hr_msk,
  input  logic [2:0] day_alm,
  input  logic       day_msk,
  output logic       hit
);

  rate_e rate;
  logic  cmp_point;
  logic  min_eq, hr_eq, day_eq;
  logic  sel_ok;

  assign rate      = decode_rate(min_msk, hr_msk, day_msk);
  assign cmp_point = tick_100hz & hund_wrap & (cur_sec == 7'h00);
  assign min_eq    = (cur_min  == min_alm);
  assign hr_eq     = (cur_hour == hr_alm);
  assign day_eq    = (cur_day  == day_alm);

  always_comb begin
    unique case (rate)
      RATE_EVERY_MIN:     sel_ok = 1'b1;
      RATE_MIN_EQ:        sel_ok = min_eq;
      RATE_HR_MIN_EQ:     sel_ok = min_eq & hr_eq;
      RATE_DAY_HR_MIN_EQ: sel_ok = min_eq & hr_eq & day_eq;
      default:            sel_ok = 1'b0;
    endcase
  end

  assign hit = cmp_point & sel_ok;

endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq #(
  parameter int unsigned PULSE_CLKS = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hit,
  input  logic                              alm_access,
  input  logic                              pulse_mode,
  input  logic                              tod_mask,
  input  logic                              route_wdog,
  input  logic                              wdog_alarm,
  output logic                              flag,
  output logic [$clog2(PULSE_CLKS+1)-1:0]   pulse_cnt,
  output logic                              alarm_irq
);

  localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CLKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_run;
  logic             tod_irq;

  assign cnt_run = (cnt_q != '0);

  // next state: a new alarm wins over a clearing access
  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (hit) begin
      flag_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (alm_access) begin
      flag_d = 1'b0;
      cnt_d  = '0;
    end else if (cnt_run) begin
      cnt_d = cnt_q - CNT_LAST;
      if (pulse_mode && (cnt_q == CNT_LAST)) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tod_irq   = flag_q & ~tod_mask;
  assign alarm_irq = route_wdog ? wdog_alarm : tod_irq;
  assign flag      = flag_q;
  assign pulse_cnt = cnt_q;

endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int unsigned PULSE_CLKS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_100hz,
  input  logic        hund_wrap,
  input  logic [6:0]  cur_sec,
  input  logic [6:0]  cur_min,
  input  logic [6:0]  cur_hour,
  input  logic [2:0]  cur_day,
  input  logic        wdog_alarm,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        alarm_irq
);

  localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1);

  logic [6:0]       min_alm, hr_alm;
  logic [2:0]       day_alm;
  logic             min_msk, hr_msk, day_msk;
  logic             route_wdog, pulse_mode, tod_mask;
  logic             alm_access;
  logic             alarm_hit;
  logic             tod_flag;
  logic [CNT_W-1:0] pulse_cnt;

  tod_alarm_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .flag       (tod_flag),
    .min_alm    (min_alm),
    .min_msk    (min_msk),
    .hr_alm     (hr_alm),
    .hr_msk     (hr_msk),
    .day_alm    (day_alm),
    .day_msk    (day_msk),
    .route_wdog (route_wdog),
    .pulse_mode (pulse_mode),
    .tod_mask   (tod_mask),
    .alm_access (alm_access),
    .bus_rdata  (bus_rdata)
  );

  tod_alarm_match u_match (
    .tick_100hz (tick_100hz),
    .hund_wrap  (hund_wrap),
    .cur_sec    (cur_sec),
    .cur_min    (cur_min),
    .cur_hour   (cur_hour),
    .cur_day    (cur_day),
    .min_alm    (min_alm),
    .min_msk    (min_msk),
    .hr_alm     (hr_alm),
    .hr_msk     (hr_msk),
    .day_alm    (day_alm),
    .day_msk    (day_msk),
    .hit        (alarm_hit)
  );

  tod_alarm_irq #(.PULSE_CLKS(PULSE_CLKS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (alarm_hit),
    .alm_access (alm_access),
    .pulse_mode (pulse_mode),
    .tod_mask   (tod_mask),
    .route_wdog (route_wdog),
    .wdog_alarm (wdog_alarm),
    .flag       (tod_flag),
    .pulse_cnt  (pulse_cnt),
    .alarm_irq  (alarm_irq)
  );

endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
  parameter int unsigned PULSE_CLKS = 6
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            hit,
  input logic                            flag,
  input logic [$clog2(PULSE_CLKS+1)-1:0] pulse_cnt,
  input logic                            alm_access,
  input logic                            min_msk,
  input logic                            hr_msk,
  input logic                            tod_mask,
  input logic                            route_wdog,
  input logic                            wdog_alarm,
  input logic                            alarm_irq,
  input logic [3:0]                      bus_addr,
  input logic [7:0]                      bus_rdata
);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_access && !hit) |=> !flag);

  // R6
  bad_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_msk && !hr_msk) |-> !hit);

  // R10
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_wdog && tod_mask) |-> !alarm_irq);

  // R13
  wdog_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_wdog |-> (alarm_irq == wdog_alarm));

  // R8
  day_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'h7) |-> (bus_rdata[6:3] == 4'b0000));

  // R11
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pulse_cnt) <= PULSE_CLKS));

  // R12
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && pulse_cnt == '0 && !alm_access) |=> flag);

endmodule

bind tod_alarm_unit tod_alarm_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit        (alarm_hit),
  .flag       (tod_flag),
  .pulse_cnt  (pulse_cnt),
  .alm_access (alm_access),
  .min_msk    (min_msk),
  .hr_msk     (hr_msk),
  .tod_mask   (tod_mask),
  .route_wdog (route_wdog),
  .wdog_alarm (wdog_alarm),
  .alarm_irq  (alarm_irq),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata)
);

// File: tb/tod_alarm_unit_test.sv
module tod_alarm_unit_test;

  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_100hz, hund_wrap, wdog_alarm;
  logic [6:0] cur_sec, cur_min, cur_hour;
  logic [2:0] cur_day;
  logic       bus_en, bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       alarm_irq;

  typedef struct {
    logic       irq;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #5 clk = ~clk;

  tod_alarm_unit #(.PULSE_CLKS(P)) uut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .hund_wrap(hund_wrap),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .wdog_alarm(wdog_alarm), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq)
  );

  // monitor: compare after the edge that ends each stimulus cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (alarm_irq !== e.irq || bus_rdata !== e.rd) begin
          n_fail++;
          $display("FAIL %s: irq=%b rdata=%02h, expected irq=%b rdata=%02h",
                   e.tag, alarm_irq, bus_rdata, e.irq, e.rd);
        end
      end
    end
  end

  task automatic step(input logic en, input logic we, input logic [3:0] a,
                      input logic [7:0] d, input logic tk, input logic rl,
                      input logic e_irq, input logic [7:0] e_rd, input string tag);
    exp_t e;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    tick_100hz = tk; hund_wrap = rl;
    e.irq = e_irq; e.rd = e_rd; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #3;
  endtask

  task automatic idle(input logic e_irq, input logic [7:0] e_rd, input string tag);
    step(1'b0, 1'b0, 4'hB, 8'h00, 1'b0, 1'b0, e_irq, e_rd, tag);
  endtask

  task automatic cpt(input logic e_irq, input logic [7:0] e_rd, input string tag);
    step(1'b0, 1'b0, 4'hB, 8'h00, 1'b1, 1'b1, e_irq, e_rd, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d,
                    input logic e_irq, input logic [7:0] e_rd, input string tag);
    step(1'b1, 1'b1, a, d, 1'b0, 1'b0, e_irq, e_rd, tag);
  endtask

  task automatic rd(input logic [3:0] a, input logic e_irq,
                    input logic [7:0] e_rd, input string tag);
    step(1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0, e_irq, e_rd, tag);
  endtask

  task automatic peek(input logic [3:0] a, input logic e_irq,
                      input logic [7:0] e_rd, input string tag);
    step(1'b0, 1'b0, a, 8'h00, 1'b0, 1'b0, e_irq, e_rd, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tick_100hz = 0; hund_wrap = 0; wdog_alarm = 0;
    cur_sec = 7'h00; cur_min = 7'h00; cur_hour = 7'h00; cur_day = 3'd1;
    bus_en = 0; bus_we = 0; bus_addr = 4'hB; bus_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1 reset state
    idle(1'b0, 8'h00, "R1 ctrl/flag");
    peek(4'h3, 1'b0, 8'h00, "R1 min alarm");
    peek(4'h7, 1'b0, 8'h00, "R1 day alarm");

    // every-minute setup
    wr(4'h3, 8'h80, 1'b0, 8'h80, "R2 setup");
    wr(4'h5, 8'h80, 1'b0, 8'h80, "R2 setup");
    wr(4'h7, 8'h80, 1'b0, 8'h80, "R2 setup");

    // R7 tick or wrap alone
    step(1'b0, 1'b0, 4'hB, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, "R7 tick only");
    step(1'b0, 1'b0, 4'hB, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R7 wrap only");

    // R2
    cur_sec = 7'h01;
    cpt(1'b0, 8'h00, "R2 seconds not 00");
    cur_sec = 7'h00;
    cpt(1'b1, 8'h01, "R2 minute alarm");

    // R12 level hold
    for (int i = 0; i < 3; i++) idle(1'b1, 8'h01, "R12 level hold");

    // R9 read-only flag, then read clears
    wr(4'hB, 8'h01, 1'b1, 8'h01, "R9 flag read-only");
    rd(4'h3, 1'b0, 8'h80, "R9 read clears");
    idle(1'b0, 8'h00, "R9 cleared");

    // R8
    wr(4'h7, 8'hFF, 1'b0, 8'h87, "R8 day pad bits");
    peek(4'h7, 1'b0, 8'h87, "R8 day pad bits");
    wr(4'h7, 8'h80, 1'b0, 8'h80, "R8 restore");

    // R3
    wr(4'h3, 8'h25, 1'b0, 8'h25, "R3 setup");
    cur_min = 7'h24;
    cpt(1'b0, 8'h00, "R3 minute mismatch");
    cur_min = 7'h25;
    cpt(1'b1, 8'h01, "R3 minute match");
    wr(4'h3, 8'h25, 1'b0, 8'h25, "R9 write clears");

    // R4
    wr(4'h5, 8'h12, 1'b0, 8'h12, "R4 setup");
    cur_hour = 7'h11;
    cpt(1'b0, 8'h00, "R4 hour mismatch");
    cur_hour = 7'h12;
    cpt(1'b1, 8'h01, "R4 hour+minute match");
    rd(4'h5, 1'b0, 8'h12, "R9 read clears");

    // R5
    wr(4'h7, 8'h03, 1'b0, 8'h03, "R5 setup");
    cur_day = 3'd2;
    cpt(1'b0, 8'h00, "R5 day mismatch");
    cur_day = 3'd3;
    cpt(1'b1, 8'h01, "R5 full match");
    rd(4'h7, 1'b0, 8'h03, "R9 read clears");

    // R6 illegal mask patterns, all fields matching
    wr(4'h3, 8'hA5, 1'b0, 8'hA5, "R6 setup 100");
    cpt(1'b0, 8'h00, "R6 pattern 100");
    wr(4'h7, 8'h83, 1'b0, 8'h83, "R6 setup 101");
    cpt(1'b0, 8'h00, "R6 pattern 101");
    wr(4'h5, 8'h92, 1'b0, 8'h92, "R6 setup 110");
    wr(4'h7, 8'h03, 1'b0, 8'h03, "R6 setup 110");
    cpt(1'b0, 8'h00, "R6 pattern 110");

    // back to every minute
    wr(4'h3, 8'h80, 1'b0, 8'h80, "setup");
    wr(4'h5, 8'h80, 1'b0, 8'h80, "setup");
    wr(4'h7, 8'h80, 1'b0, 8'h80, "setup");

    // R10 masked interrupt
    wr(4'hB, 8'h04, 1'b0, 8'h04, "R10 setup");
    cpt(1'b0, 8'h05, "R10 masked irq, flag set");
    idle(1'b0, 8'h05, "R10 masked irq");
    rd(4'h3, 1'b0, 8'h80, "R10 clear");
    idle(1'b0, 8'h04, "R10 cleared");

    // R11 pulse mode
    wr(4'hB, 8'h10, 1'b0, 8'h10, "R11 setup");
    cpt(1'b1, 8'h11, "R11 pulse start");
    for (int i = 1; i < P; i++) idle(1'b1, 8'h11, "R11 pulse active");
    idle(1'b0, 8'h10, "R11 pulse end");
    idle(1'b0, 8'h10, "R11 pulse end");

    // R13 routing
    wr(4'hB, 8'h40, 1'b0, 8'h40, "R13 setup");
    wdog_alarm = 1'b1;
    idle(1'b1, 8'h40, "R13 watchdog high");
    wdog_alarm = 1'b0;
    idle(1'b0, 8'h40, "R13 watchdog low");
    cpt(1'b0, 8'h41, "R13 tod alarm hidden");
    wr(4'hB, 8'h00, 1'b1, 8'h01, "R13 route back, R12 level");
    rd(4'h3, 1'b0, 8'h80, "R9 read clears");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule